// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models the device side of a small serial nonvolatile memory that a host reaches over a select line, a serial clock, a data input and a data output. It holds 1024 bits in a register array. A strap input arranges the array as 64 words of 16 bits or as 128 words of 8 bits. The host shifts in a start bit, a two-bit opcode and an address. Some commands also carry a data word. The block then streams words out, latches a program request, or changes its write-enable state.

Programming commands take effect when the host drops the select line. They then run for a fixed number of system clocks with no serial clock needed. While one runs, a host that raises select can poll the data output, which is low while busy and high once done. The serial pins are brought into the system clock domain and their edges are found there, so each serial clock phase must last at least two system clocks. The output enable is a separate port, so a pad cell can tri-state the data line.

Top module: `serial_nvm_target`

## Requirements
- R1: With the strap high the array is 64x16 and the address field is 6 bits. With the strap low it is 128x8 and the address field is 7 bits. Each instruction is a start bit of 1, then a 2-bit opcode, then the address, MSB first. Zeros before the start bit are ignored.
- R2: Opcode 10 reads, 01 writes one word and 11 erases one word. With opcode 00, the two top address bits choose the command: 11 sets the write-enable latch, 00 clears it, 10 erases all words and 01 writes one data word into every word. The lower address bits are don't-care.
- R3: Data input is sampled on a rising serial clock edge. During a read the data output moves to its next bit after each rising serial clock edge and is valid by the next one.
- R4: A read first shows a single 0 after the last address bit, then the word MSB first. Further clocks stream the following words without another 0. The address wraps from the top word to word 0.
- R5: A read works whether the write-enable latch is set or clear.
- R6: Reset clears the write-enable latch. Write, erase, erase-all and write-all are dropped while the latch is clear, and the latch holds until a clear command or reset. Reset does not alter stored data.
- R7: A program command takes effect on the select falling edge after its last bit. An instruction cut short by select going low is dropped.
- R8: Erase and erase-all leave the target words all ones. Write replaces a word with no prior erase, and write-all puts the same word into every location.
- R9: A program cycle lasts PROG_CYCLES system clocks. Raising select during it drives the data output low, and the output goes high after the cycle ends.
- R10: The output enable is low whenever select is low and after reset.
- R11: Any instruction sent while a program cycle is running is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| org_wide_i | input | 1 | Organization strap: 1 = 64x16, 0 = 128x8 |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data / ready status to host |
| sdo_oe_o | output | 1 | Output enable for the data line |

## Verification
The one real overlap is a new instruction arriving while a self-timed program cycle is still counting. The block then has to drop the new bits and still report busy to the host. The bench provokes this by committing one write and at once shifting in a full second write to a different address while the first cycle runs. The cycle is made long enough that the whole second instruction lands inside it. It judges the result by polling for busy and then ready, and by reading back both addresses: only the first may have changed. Random writes in both organizations are compared against a model array in the bench, and streamed reads across the wrap point cover address increment.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int WORDS    = 64;
    localparam int IDX_W    = $clog2(WORDS);
    localparam int ADR_W    = IDX_W + 1;
    localparam int BITCNT_W = $clog2(WORD_W);

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPC, PH_ADR, PH_DAT, PH_RD, PH_ARM
    } phase_t;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_READ, CMD_WRITE, CMD_ERASE,
        CMD_ERALL, CMD_WRALL, CMD_WEN, CMD_WDIS
    } cmd_t;

    typedef struct packed {
        logic              en;
        logic              all;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] mask;
    } wr_req_t;

    function automatic cmd_t decode_cmd(input logic [1:0] opc, input logic [1:0] ext);
        cmd_t c;
        case (opc)
            2'b10:   c = CMD_READ;
            2'b01:   c = CMD_WRITE;
            2'b11:   c = CMD_ERASE;
            default: begin
                case (ext)
                    2'b11:   c = CMD_WEN;
                    2'b00:   c = CMD_WDIS;
                    2'b10:   c = CMD_ERALL;
                    default: c = CMD_WRALL;
                endcase
            end
        endcase
        return c;
    endfunction

    function automatic logic is_prog(input cmd_t c);
        return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_ERALL) || (c == CMD_WRALL);
    endfunction

    // Byte lane for the narrow organization: address bit 0 picks the upper byte.
    function automatic logic [WORD_W-1:0] lane_mask(input logic wide, input logic hi);
        if (wide)    return '1;
        else if (hi) return {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
        else         return {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    endfunction

    function automatic logic [WORD_W-1:0] spread(input logic wide, input logic [WORD_W-1:0] d);
        return wide ? d : {d[BYTE_W-1:0], d[BYTE_W-1:0]};
    endfunction

endpackage

// File: rtl/nvm_in_sync.sv
module nvm_in_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl
);
    logic [N-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= (s == 0) ? din : chain[(s == 0) ? 0 : s - 1];
        end
    end

    assign lvl = chain[STAGES-1];
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CW'(CYCLES - 1)) busy <= 1'b0;
            cnt <= cnt + 1'b1;
        end
    end

    assert_start_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    assert_cycle_bounded_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < CW'(CYCLES)));
endmodule

// File: rtl/nvm_array.sv
module nvm_array
    import nvm_pkg::*;
(
    input  logic              clk,
    input  wr_req_t           req,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (req.en && (req.all || req.idx == IDX_W'(i)))
                mem[i] <= (mem[i] & ~req.mask) | (req.data & req.mask);
        end
    end

    assign rd_word = mem[rd_idx];
endmodule

// File: rtl/serial_nvm_target.sv
module serial_nvm_target
    import nvm_pkg::*;
#(
    parameter int PROG_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic org_wide_i,
    input  logic cs_i,
    input  logic sck_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);
    logic [2:0] pins;
    logic cs_lvl, sck_lvl, di, cs_prev, sck_prev;
    logic cs_fall, cs_rise, sck_rise;

    nvm_in_sync #(.N(3), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din({sdi_i, sck_i, cs_i}), .lvl(pins));
    assign {di, sck_lvl, cs_lvl} = pins;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev  <= 1'b0;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_lvl;
            sck_prev <= sck_lvl;
        end
    end
    assign cs_fall  = cs_prev & ~cs_lvl;
    assign cs_rise  = ~cs_prev & cs_lvl;
    assign sck_rise = ~sck_prev & sck_lvl;

    phase_t               phase;
    cmd_t                 pend;
    logic [BITCNT_W-1:0]  cnt;
    logic [1:0]           opc;
    logic [ADR_W-1:0]     adr;
    logic [WORD_W-1:0]    dat, rd_sh;
    logic                 wen_q, ld_q, rd_do_q, stat_vis, oe_q, t_busy;
    logic                 wide;
    logic [BITCNT_W-1:0]  adr_last, dat_last;
    logic [ADR_W-1:0]     adr_n;
    logic [1:0]           ext;
    cmd_t                 dec;
    logic [WORD_W-1:0]    rd_word;
    logic [IDX_W-1:0]     word_idx;
    wr_req_t              wr;
    logic                 commit;

    assign wide     = org_wide_i;
    assign adr_last = wide ? BITCNT_W'(IDX_W - 1) : BITCNT_W'(ADR_W - 1);
    assign dat_last = wide ? BITCNT_W'(WORD_W - 1) : BITCNT_W'(BYTE_W - 1);
    assign adr_n    = {adr[ADR_W-2:0], di};
    assign ext      = wide ? adr_n[IDX_W-1:IDX_W-2] : adr_n[ADR_W-1:ADR_W-2];
    assign dec      = decode_cmd(opc, ext);
    assign word_idx = wide ? adr[IDX_W-1:0] : adr[ADR_W-1:1];
    assign commit   = cs_fall && (phase == PH_ARM);

    always_comb begin
        wr = '0;
        if (commit && is_prog(pend) && wen_q && !t_busy) begin
            wr.en  = 1'b1;
            wr.idx = word_idx;
            case (pend)
                CMD_WRITE: begin wr.data = spread(wide, dat); wr.mask = lane_mask(wide, adr[0]); end
                CMD_ERASE: begin wr.data = '1;                wr.mask = lane_mask(wide, adr[0]); end
                CMD_ERALL: begin wr.all = 1'b1; wr.data = '1; wr.mask = '1; end
                default:   begin wr.all = 1'b1; wr.data = spread(wide, dat); wr.mask = '1; end
            endcase
        end
    end

    nvm_array u_array (.clk(clk), .req(wr), .rd_idx(word_idx), .rd_word(rd_word));

    nvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(wr.en), .busy(t_busy));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            pend     <= CMD_NONE;
            cnt      <= '0;
            opc      <= '0;
            adr      <= '0;
            dat      <= '0;
            rd_sh    <= '0;
            wen_q    <= 1'b0;
            ld_q     <= 1'b0;
            rd_do_q  <= 1'b0;
            stat_vis <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            oe_q <= cs_lvl && (phase == PH_RD || stat_vis);
            if (commit && pend == CMD_WEN)  wen_q <= 1'b1;
            if (commit && pend == CMD_WDIS) wen_q <= 1'b0;
            if (cs_rise && t_busy) stat_vis <= 1'b1;
            if (!cs_lvl) begin
                phase    <= PH_IDLE;
                stat_vis <= 1'b0;
                ld_q     <= 1'b0;
            end else begin
                case (phase)
                    PH_IDLE: if (sck_rise && di && !t_busy) begin
                        phase    <= PH_OPC;
                        cnt      <= '0;
                        stat_vis <= 1'b0;
                    end
                    PH_OPC: if (sck_rise) begin
                        opc <= {opc[0], di};
                        cnt <= cnt + 1'b1;
                        if (cnt == BITCNT_W'(1)) begin
                            phase <= PH_ADR;
                            cnt   <= '0;
                        end
                    end
                    PH_ADR: if (sck_rise) begin
                        adr <= adr_n;
                        cnt <= cnt + 1'b1;
                        if (cnt == adr_last) begin
                            if (wide) adr <= {1'b0, adr_n[IDX_W-1:0]};
                            pend <= dec;
                            cnt  <= '0;
                            case (dec)
                                CMD_READ: begin
                                    phase   <= PH_RD;
                                    rd_do_q <= 1'b0;
                                    ld_q    <= 1'b1;
                                end
                                CMD_WRITE, CMD_WRALL: phase <= PH_DAT;
                                default:              phase <= PH_ARM;
                            endcase
                        end
                    end
                    PH_DAT: if (sck_rise) begin
                        dat <= {dat[WORD_W-2:0], di};
                        cnt <= cnt + 1'b1;
                        if (cnt == dat_last) phase <= PH_ARM;
                    end
                    PH_RD: begin
                        if (ld_q) begin
                            ld_q  <= 1'b0;
                            rd_sh <= wide ? rd_word
                                   : {(adr[0] ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0]),
                                      {BYTE_W{1'b0}}};
                        end else if (sck_rise) begin
                            rd_do_q <= rd_sh[WORD_W-1];
                            rd_sh   <= {rd_sh[WORD_W-2:0], 1'b0};
                            cnt     <= cnt + 1'b1;
                            if (cnt == dat_last) begin
                                cnt  <= '0;
                                ld_q <= 1'b1;
                                adr  <= wide ? {1'b0, adr[IDX_W-1:0] + 1'b1} : adr + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sdo_oe_o = oe_q;
    assign sdo_o    = oe_q & ((phase == PH_RD) ? rd_do_q : !t_busy);

    assert_hiz_deselect_R10: assert property (@(posedge clk) disable iff (rst)
        !cs_lvl |=> !sdo_oe_o);
    assert_locked_no_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(t_busy) |-> $past(wen_q));
    assert_quiet_while_busy_R11: assert property (@(posedge clk) disable iff (rst)
        t_busy |-> (phase == PH_IDLE));
    assert_dummy_zero_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(phase == PH_RD) |-> !rd_do_q);
endmodule

// File: tb/tb_serial_nvm_target.sv
module tb_serial_nvm_target;
    localparam int PROG = 600;

    logic clk = 1'b0, rst = 1'b1, wide = 1'b1, cs = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic sdo, oe;
    int total = 0, bad = 0;
    logic [15:0] m16 [64];
    logic [7:0]  m8  [128];

    always #10 clk = ~clk;

    serial_nvm_target #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst(rst), .org_wide_i(wide), .cs_i(cs), .sck_i(sck),
        .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(oe));

    task automatic tick(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        sdi = b; tick(2); sck = 1'b1; tick(4); sck = 1'b0; tick(2);
    endtask

    task automatic cs_down; cs = 1'b0; sck = 1'b0; tick(6); endtask

    function automatic logic [6:0] ext_adr(input logic [1:0] e);
        return wide ? {1'b0, e, 4'b0} : {e, 5'b0};
    endfunction

    task automatic send_hdr(input logic [1:0] opc, input logic [6:0] a);
        int aw = wide ? 6 : 7;
        bit_out(1'b1); bit_out(opc[1]); bit_out(opc[0]);
        for (int i = aw - 1; i >= 0; i--) bit_out(a[i]);
    endtask

    task automatic prog(input logic [1:0] opc, input logic [6:0] a, input bit has_d, input logic [15:0] d);
        int dw = wide ? 16 : 8;
        cs = 1'b1; tick(2);
        send_hdr(opc, a);
        if (has_d) for (int b = dw - 1; b >= 0; b--) bit_out(d[b]);
        cs_down();
    endtask

    // R9: busy low then ready high while select held; otherwise nothing started
    task automatic status_wait(input bit exp_busy, input string tag);
        cs = 1'b1; tick(8);
        if (exp_busy) begin
            chk(oe === 1'b1 && sdo === 1'b0, {tag, " R9 busy"}, {14'b0, oe, sdo}, 16'h2);
            tick(PROG + 40);
            chk(oe === 1'b1 && sdo === 1'b1, {tag, " R9 ready"}, {14'b0, oe, sdo}, 16'h3);
        end else begin
            chk(oe === 1'b0, {tag, " no cycle"}, {15'b0, oe}, 16'h0);
        end
        cs_down();
    endtask

    task automatic read_chk(input logic [6:0] a, input int nw, input string tag);
        int dw = wide ? 16 : 8;
        int nwords = wide ? 64 : 128;
        int idx = wide ? int'(a[5:0]) : int'(a);
        logic [15:0] got, exp;
        cs = 1'b1; tick(2);
        send_hdr(2'b10, a);
        chk(oe === 1'b1 && sdo === 1'b0, {tag, " R4 dummy R3"}, {14'b0, oe, sdo}, 16'h2);
        for (int w = 0; w < nw; w++) begin
            got = '0;
            for (int b = 0; b < dw; b++) begin bit_out(1'b0); got = {got[14:0], sdo}; end
            exp = wide ? m16[idx] : {8'h0, m8[idx]};
            chk(got === exp, {tag, " R4 data"}, got, exp);
            idx = (idx + 1) % nwords;
        end
        cs_down();
    endtask

    initial begin
        #(20 * 190000);
        bad++; total++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [6:0] a;
        logic [15:0] d;
        void'($urandom(32'd1234));
        tick(4); rst = 1'b0; tick(4);
        chk(oe === 1'b0, "R10 reset", {15'b0, oe}, 16'h0);

        // R1/R2 wide organization: enable, erase-all
        prog(2'b00, ext_adr(2'b11), 0, '0);
        prog(2'b00, ext_adr(2'b10), 0, '0);
        status_wait(1, "R2 erase-all");
        for (int i = 0; i < 64; i++) m16[i] = 16'hFFFF;
        read_chk(7'd0, 2, "R8 erase-all");

        // R6 locked write dropped, R5 read while locked
        prog(2'b00, ext_adr(2'b00), 0, '0);
        prog(2'b01, 7'd5, 1, 16'h1234);
        status_wait(0, "R6 locked");
        read_chk(7'd5, 1, "R5 R6");

        // random writes
        prog(2'b00, ext_adr(2'b11), 0, '0);
        for (int k = 0; k < 8; k++) begin
            a = 7'($urandom % 64); d = 16'($urandom);
            prog(2'b01, a, 1, d);
            status_wait(1, "R7 write");
            m16[a[5:0]] = d;
        end
        prog(2'b01, 7'd63, 1, 16'hBEEF); status_wait(1, "R7"); m16[63] = 16'hBEEF;
        read_chk(7'd62, 4, "R4 wrap x16");
        read_chk(7'($urandom % 64), 3, "R1 x16");

        // R8 overwrite without erase, then erase
        prog(2'b01, 7'd10, 1, 16'h00F0); status_wait(1, "R8");
        prog(2'b01, 7'd10, 1, 16'h0F0F); status_wait(1, "R8"); m16[10] = 16'h0F0F;
        read_chk(7'd10, 1, "R8 overwrite");
        prog(2'b11, 7'd10, 0, '0); status_wait(1, "R8 erase"); m16[10] = 16'hFFFF;
        read_chk(7'd10, 1, "R8 erase");

        // R7 truncated write
        cs = 1'b1; tick(2); send_hdr(2'b01, 7'd10);
        for (int b = 0; b < 8; b++) bit_out(1'b0);
        cs_down();
        status_wait(0, "R7 truncated");
        read_chk(7'd10, 1, "R7 truncated");

        // R11 instruction during program cycle
        prog(2'b01, 7'd20, 1, 16'hAAAA); m16[20] = 16'hAAAA;
        prog(2'b01, 7'd21, 1, 16'h5555);
        status_wait(1, "R11");
        read_chk(7'd20, 2, "R11 second dropped");

        // R8 write-all
        prog(2'b00, ext_adr(2'b01), 1, 16'hC3A5); status_wait(1, "R8 write-all");
        for (int i = 0; i < 64; i++) m16[i] = 16'hC3A5;
        read_chk(7'd30, 2, "R8 write-all");

        // R1 narrow organization
        wide = 1'b0; tick(4);
        prog(2'b00, ext_adr(2'b10), 0, '0); status_wait(1, "R1 x8 erase-all");
        for (int i = 0; i < 128; i++) m8[i] = 8'hFF;
        for (int k = 0; k < 8; k++) begin
            a = 7'($urandom % 128); d = 16'($urandom % 256);
            prog(2'b01, a, 1, d); status_wait(1, "R1 x8 write");
            m8[a] = d[7:0];
        end
        prog(2'b01, 7'd127, 1, 16'h005A); status_wait(1, "R1"); m8[127] = 8'h5A;
        prog(2'b01, 7'd0, 1, 16'h00A5); status_wait(1, "R1"); m8[0] = 8'hA5;
        read_chk(7'd126, 4, "R4 wrap x8");
        read_chk(7'($urandom % 128), 3, "R1 x8");

        // R6 reset clears latch, data kept
        rst = 1'b1; tick(2); rst = 1'b0; tick(4);
        chk(oe === 1'b0, "R10 after reset", {15'b0, oe}, 16'h0);
        prog(2'b01, 7'd0, 1, 16'h0011);
        status_wait(0, "R6 reset latch");
        read_chk(7'd0, 1, "R6 data kept");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule